// File: doc/BRIEF.md
# Strobed Serial Sample Receiver

This block takes in the three-wire serial output of a sampling converter: an active-low frame strobe, a serial clock and a data line. The strobe and clock idle high. All three inputs are asynchronous to the system clock, so each passes through a two-flop synchroniser before use. A falling edge on the synchronised strobe opens a frame. Each later rising edge of the synchronised serial clock samples one bit. The frame carries a fixed number of padding bits, which should be zero, followed by a 14-bit sample sent most significant bit first.

When the last bit arrives, the receiver latches the sample into a parallel output and raises a one-cycle valid pulse. It then ignores the serial clock until the next strobe. Because of this, the block works the same whether the converter keeps its clock running between frames or stops it (held high) after the last bit. A padding bit that reads as one is reported through an error flag that travels with the word. A strobe that arrives while a frame is partly received discards the partial word and starts a new capture.

Top module: `strobed_sample_rx`

## Requirements
- R1: During and right after reset, `word_o` is all zeros and both `word_valid_o` and `lead_err_o` are low.
- R2: Rising serial clock edges seen before any frame has been opened by a falling strobe edge produce no valid pulse and leave `word_o` unchanged.
- R3: A frame is LEAD_BITS padding bits (default 2) followed by DATA_BITS (14) data bits, each sampled on a rising serial clock edge. The first data bit sampled becomes bit 13 of `word_o`, and the last becomes bit 0.
- R4: Every complete frame produces exactly one `word_valid_o` pulse, one system clock cycle wide, within 6 system cycles of the last rising serial clock edge.
- R5: Rising serial clock edges after a frame has completed, and before the next falling strobe edge, produce no valid pulse and do not change `word_o`. A free-running clock is therefore tolerated.
- R6: `lead_err_o` is updated together with each valid pulse. It is high when any padding bit of that frame was one, and low otherwise.
- R7: A falling strobe edge in the middle of a frame discards the bits received so far without a valid pulse. The next full frame is delivered intact.
- R8: `word_o` and `lead_err_o` hold their values in every cycle in which `word_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Frame strobe from the converter, active low, idle high |
| sclk_i | input | 1 | Serial clock from the converter, idle high |
| sdata_i | input | 1 | Serial data, sampled on the rising serial clock edge |
| word_o | output | DATA_BITS | Last received sample |
| word_valid_o | output | 1 | One-cycle pulse when `word_o` is updated |
| lead_err_o | output | 1 | A padding bit of the last frame was one |

## Verification
A bit counter that is wrong shows up at the ports in one of three ways. It can shift the word by one or more places. It can drop the valid pulse altogether. Or it can produce a spurious pulse when clock edges arrive after the frame, and that pulse appears within a few system cycles of the offending edge. A receiver that fails to leave or re-enter its capture state shows up the same way. With the clock left running after a frame, or with a strobe in mid-frame, it either emits an extra word or delivers a corrupted one on the next valid pulse. A padding flag that is not cleared when a frame starts stays high on the next clean frame's valid pulse.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  typedef enum logic {
    RX_IDLE  = 1'b0,
    RX_SHIFT = 1'b1
  } rx_state_e;
endpackage

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssr_edge.sv
module ssr_edge #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= IDLE_LVL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/ssr_deser.sv
module ssr_deser
  import ssr_pkg::*;
#(
  parameter int unsigned LEAD_BITS = 2,
  parameter int unsigned DATA_BITS = 14,
  localparam int unsigned FRAME_BITS = LEAD_BITS + DATA_BITS,
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 bit_en_i,
  input  logic                 bit_i,
  output logic [DATA_BITS-1:0] word_o,
  output logic                 valid_o,
  output logic                 err_o,
  output logic                 in_frame_o,
  output logic [CNT_W-1:0]     bit_cnt_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] LEAD_C   = CNT_W'(LEAD_BITS);

  rx_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [DATA_BITS-1:0] shift_q;
  logic                 lead_bad_q;
  logic [DATA_BITS-1:0] shift_nxt;
  logic                 in_lead;

  assign in_lead   = (cnt_q < LEAD_C);
  assign shift_nxt = {shift_q[DATA_BITS-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      cnt_q      <= '0;
      shift_q    <= '0;
      lead_bad_q <= 1'b0;
      word_o     <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        // strobe wins: fresh frame, partial bits dropped
        state_q    <= RX_SHIFT;
        cnt_q      <= '0;
        lead_bad_q <= 1'b0;
      end else if (state_q == RX_SHIFT && bit_en_i) begin
        if (in_lead) lead_bad_q <= lead_bad_q | bit_i;
        else         shift_q    <= shift_nxt;
        if (cnt_q == LAST_IDX) begin
          state_q <= RX_IDLE;
          cnt_q   <= '0;
          word_o  <= shift_nxt;
          valid_o <= 1'b1;
          err_o   <= lead_bad_q | (in_lead & bit_i);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign in_frame_o = (state_q == RX_SHIFT);
  assign bit_cnt_o  = cnt_q;
endmodule

// File: rtl/strobed_sample_rx.sv
module strobed_sample_rx #(
  parameter int unsigned LEAD_BITS   = 2,
  parameter int unsigned DATA_BITS   = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 strobe_i,
  input  logic                 sclk_i,
  input  logic                 sdata_i,
  output logic [DATA_BITS-1:0] word_o,
  output logic                 word_valid_o,
  output logic                 lead_err_o
);
  localparam int unsigned FRAME_BITS = LEAD_BITS + DATA_BITS;
  localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

  logic [2:0]       pins_sync;
  logic             strobe_fall;
  logic             strobe_rise_unused;
  logic             sclk_rise;
  logic             sclk_fall_unused;
  logic             in_frame;
  logic [CNT_W-1:0] bit_cnt;

  // open-drain lines idle high; data idles high as well
  ssr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({strobe_i, sclk_i, sdata_i}),
    .q_o   (pins_sync)
  );

  ssr_edge #(.IDLE_LVL(1'b1)) u_strobe_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_sync[2]),
    .rise_o(strobe_rise_unused),
    .fall_o(strobe_fall)
  );

  ssr_edge #(.IDLE_LVL(1'b1)) u_sclk_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (pins_sync[1]),
    .rise_o(sclk_rise),
    .fall_o(sclk_fall_unused)
  );

  ssr_deser #(.LEAD_BITS(LEAD_BITS), .DATA_BITS(DATA_BITS)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (strobe_fall),
    .bit_en_i  (sclk_rise),
    .bit_i     (pins_sync[0]),
    .word_o    (word_o),
    .valid_o   (word_valid_o),
    .err_o     (lead_err_o),
    .in_frame_o(in_frame),
    .bit_cnt_o (bit_cnt)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int unsigned DATA_BITS  = 14,
  parameter int unsigned FRAME_BITS = 16,
  parameter int unsigned CNT_W      = 5
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [DATA_BITS-1:0] word_o,
  input logic                 word_valid_o,
  input logic                 lead_err_o,
  input logic                 in_frame,
  input logic [CNT_W-1:0]     bit_cnt,
  input logic                 strobe_fall
);
  p_valid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |=> !word_valid_o);

  p_valid_from_frame_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> ($past(in_frame) && !in_frame));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt < CNT_W'(FRAME_BITS));

  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_fall |=> (in_frame && bit_cnt == '0 && !word_valid_o));

  p_hold_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(word_o));

  p_hold_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_valid_o |-> $stable(lead_err_o));
endmodule

bind strobed_sample_rx ssr_checker #(
  .DATA_BITS (DATA_BITS),
  .FRAME_BITS(FRAME_BITS),
  .CNT_W     (CNT_W)
) u_ssr_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_o      (word_o),
  .word_valid_o(word_valid_o),
  .lead_err_o  (lead_err_o),
  .in_frame    (in_frame),
  .bit_cnt     (bit_cnt),
  .strobe_fall (strobe_fall)
);

// File: tb/strobed_sample_rx_bench.sv
module strobed_sample_rx_bench;
  localparam int LEAD = 2;
  localparam int DW   = 14;
  localparam int FB   = LEAD + DW;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic strobe = 1'b1;
  logic sclk = 1'b1;
  logic sdata = 1'b1;
  logic [DW-1:0] word;
  logic valid;
  logic err;

  int total = 0;
  int bad = 0;
  int vcount = 0;
  int wide = 0;
  int last_rise = 0;
  int cyc = 0;
  int lat_max = 0;
  logic prev_valid = 1'b0;
  logic [DW-1:0] cap_word = '0;
  logic cap_err = 1'b0;

  always #10 clk = ~clk;

  strobed_sample_rx u_strobed_sample_rx (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .strobe_i    (strobe),
    .sclk_i      (sclk),
    .sdata_i     (sdata),
    .word_o      (word),
    .word_valid_o(valid),
    .lead_err_o  (err)
  );

  always @(negedge clk) begin
    cyc++;
    if (valid) begin
      vcount++;
      cap_word = word;
      cap_err  = err;
      if (cyc - last_rise > lat_max) lat_max = cyc - last_rise;
      if (prev_valid) wide++;
    end
    prev_valid = valid;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe_pulse();
    @(negedge clk);
    strobe = 1'b0;
    idle(HALF);
    strobe = 1'b1;
    idle(HALF);
  endtask

  task automatic send_bits(input logic [FB-1:0] bits, input int n);
    for (int i = FB - 1; i >= FB - n; i--) begin
      sclk  = 1'b0;
      sdata = bits[i];
      idle(HALF);
      sclk = 1'b1;
      last_rise = cyc;
      idle(HALF);
    end
  endtask

  task automatic frame(input logic [LEAD-1:0] lead, input logic [DW-1:0] data);
    strobe_pulse();
    send_bits({lead, data}, FB);
    idle(12);
  endtask

  task automatic t_reset();
    idle(3);
    check(word == '0, "R1 word", 32'(word), 0);
    check(valid == 1'b0 && err == 1'b0, "R1 valid/err", {30'd0, valid, err}, 0);
    rst_ni = 1'b1;
    idle(3);
    check(word == '0 && !valid && !err, "R1 after release", 32'(word), 0);
  endtask

  task automatic t_idle_edges();
    int v0 = vcount;
    send_bits(16'h5AA5, 8);
    idle(12);
    check(vcount == v0, "R2 valid count", 32'(vcount - v0), 0);
    check(word == '0, "R2 word", 32'(word), 0);
  endtask

  task automatic t_word(input logic [DW-1:0] data);
    int v0 = vcount;
    frame(2'b00, data);
    check(vcount == v0 + 1, "R4 one pulse", 32'(vcount - v0), 1);
    check(cap_word == data, "R3 word", 32'(cap_word), 32'(data));
    check(cap_err == 1'b0, "R6 err clear", 32'(cap_err), 0);
  endtask

  task automatic t_lead_err();
    int v0 = vcount;
    frame(2'b01, 14'h0F0F);
    check(vcount == v0 + 1 && cap_err == 1'b1, "R6 err set", 32'(cap_err), 1);
    check(cap_word == 14'h0F0F, "R6 word with err", 32'(cap_word), 32'h0F0F);
    frame(2'b10, 14'h0001);
    check(cap_err == 1'b1, "R6 err msb lead", 32'(cap_err), 1);
    frame(2'b00, 14'h1111);
    check(cap_err == 1'b0 && err == 1'b0, "R6 err cleared", 32'(err), 0);
  endtask

  task automatic t_trailing();
    int v0 = vcount;
    logic [DW-1:0] w0 = word;
    send_bits(16'hFFFF, 10);
    idle(12);
    check(vcount == v0, "R5 no pulse", 32'(vcount - v0), 0);
    check(word == w0, "R5 word kept", 32'(word), 32'(w0));
  endtask

  task automatic t_abort();
    int v0 = vcount;
    strobe_pulse();
    send_bits(16'h3FFF, 7);
    frame(2'b00, 14'h1234);
    check(vcount == v0 + 1, "R7 single pulse", 32'(vcount - v0), 1);
    check(cap_word == 14'h1234, "R7 restarted word", 32'(cap_word), 32'h1234);
  endtask

  task automatic t_hold();
    logic [DW-1:0] w0 = word;
    logic e0 = err;
    idle(100);
    check(word == w0 && err == e0, "R8 hold", 32'(word), 32'(w0));
  endtask

  initial begin
    t_reset();
    t_idle_edges();
    t_word(14'h2A5C);
    t_word(14'h3FFF);
    t_word(14'h0001);
    t_word(14'h2000);
    t_lead_err();
    t_word(14'h1E3C);
    t_trailing();
    t_abort();
    t_hold();
    check(wide == 0, "R4 pulse width", 32'(wide), 0);
    check(lat_max <= 6, "R4 latency", 32'(lat_max), 6);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule